// File: doc/BRIEF.md
# ROM-Overlaid GPIO Port

This block sits inside a cartridge read-only memory and places a small general-purpose I/O port on top of three halfword locations of the ROM address space. A host bus presents a halfword address together with read and write strobes and write data. The block forwards the address to a synchronous ROM array and returns either the ROM word or one of three 16-bit port registers, which hold pin levels, pin directions and a global access mode. It drives four bidirectional pins through per-pin output enables. It also passes an active-high peripheral interrupt out to the cart as an active-low line.

After reset the port is write-only: software can program it, but every read, including reads of the three port locations, returns ROM contents, so an unaware program sees a plain ROM. Setting the mode bit lets reads of those locations return register state. A typical three-wire clock peripheral uses pin 0 as its serial clock, pin 1 as serial data and pin 2 as its chip select. Software sets the direction to 0b0111 while shifting data out and to 0b0101 while sampling data in.

Top module: `cart_gpio_overlay`

## Requirements
- R1: After reset the level, direction and mode registers are 0. All output enables are low, and a read of halfword 0x62 returns the ROM word.
- R2: Only the low four bits of the level and direction registers and bit 0 of the mode register can be written. All other bits read back as 0.
- R3: While mode bit 0 is 0, reads of halfwords 0x62 (level), 0x63 (direction) and 0x64 (mode) return the ROM word at that address.
- R4: While mode bit 0 is 1, reads of those three halfwords return register contents. A read issued in the cycle after a write to the same register returns the written value. Read data is valid in the cycle after the read strobe.
- R5: Writes to any other halfword change no register and no pin, and reads of any other halfword always return the ROM word.
- R6: Bit i of the direction register is the output enable of pin i (1 = drive). A pin outputs its level bit only when enabled and outputs 0 otherwise.
- R7: A level read returns the latched level bit for output pins and the external pin level for input pins. The external level is taken through a two-flop synchronizer, so a change shows in a read strobed two or more cycles later.
- R8: The cart interrupt output is the inverse of the peripheral interrupt input, with no clock delay.
- R9: Mode bit 0 is one global bit that switches all three locations together. Writing a value with bit 0 clear, even with other bits set, returns the port to write-only mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Halfword address from the host |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| rom_addr | output | 12 | Address to the synchronous ROM array |
| rom_rdata | input | 16 | ROM word, one cycle after rom_addr |
| pin_in | input | 4 | External pin levels |
| pin_out | output | 4 | Pin drive values |
| pin_oe | output | 4 | Per-pin output enables |
| periph_irq | input | 1 | Peripheral interrupt, active high |
| cart_irq_n | output | 1 | Cart interrupt, active low |

## Verification
On every cycle, the assertions check four things. A read that misses the port, or that hits it in write-only mode, yields the ROM word. Register state stays constant when no write strobe is present. Output enables and the mode bit take exactly the value written. No pin shows a drive value while its enable is low. Only the bench scenarios can show the rest: the merged level view with its two-cycle synchronizer delay, the masking of unused bits on read-back, and the write-then-read timing. They also show that the mode bit switches all three locations at once, including a write that sets only high bits.

// File: rtl/gpio_ovl_pkg.sv
package gpio_ovl_pkg;
  localparam int unsigned BYTE_OFS_LEVEL = 'hC4;
  localparam int unsigned BYTE_OFS_DIR   = 'hC6;
  localparam int unsigned BYTE_OFS_MODE  = 'hC8;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_LEVEL = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_MODE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_n;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_raw,
  output logic [PINS-1:0] pin_sync
);
  for (genvar i = 0; i < PINS; i++) begin : g_bit
    logic meta_q, stable_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= pin_raw[i];
        stable_q <= meta_q;
      end
    end
    assign pin_sync[i] = stable_q;
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_ovl_pkg::*;
#(
  parameter int unsigned PINS   = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          sel,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PINS-1:0]   pin_sync,
  output logic [DATA_W-1:0] level_view,
  output logic [DATA_W-1:0] dir_view,
  output logic [DATA_W-1:0] mode_view,
  output logic              mode_rw,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  localparam logic [DATA_W-1:0] PIN_MASK  = DATA_W'((1 << PINS) - 1);
  localparam logic [DATA_W-1:0] MODE_MASK = DATA_W'(1);

  logic [DATA_W-1:0] level_q, level_n;
  logic [DATA_W-1:0] dir_q,   dir_n;
  logic [DATA_W-1:0] mode_q,  mode_n;
  logic              level_en, dir_en, mode_en;
  logic [DATA_W-1:0] ext_wide;

  always_comb begin
    level_en = wr && (sel == SEL_LEVEL);
    dir_en   = wr && (sel == SEL_DIR);
    mode_en  = wr && (sel == SEL_MODE);
    level_n  = wdata & PIN_MASK;
    dir_n    = wdata & PIN_MASK;
    mode_n   = wdata & MODE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level_q <= '0;
    else if (level_en) level_q <= level_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_n;
  end

  always_comb begin
    ext_wide   = DATA_W'(pin_sync);
    level_view = (level_q & dir_q) | (ext_wide & ~dir_q & PIN_MASK);
    dir_view   = dir_q;
    mode_view  = mode_q;
    mode_rw    = mode_q[0];
    pin_oe     = dir_q[PINS-1:0];
    pin_out    = level_q[PINS-1:0] & dir_q[PINS-1:0];
  end

  assert_dir_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_DIR) |=> (pin_oe == $past(wdata[PINS-1:0])));

  assert_undriven_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~pin_oe) == '0));

  assert_hold_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(level_q) && $stable(dir_q) && $stable(mode_q)));

  assert_mode_global_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_MODE) |=> (mode_rw == $past(wdata[0])));
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_ovl_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  reg_sel_e          sel,
  input  logic              mode_rw,
  input  logic [DATA_W-1:0] level_view,
  input  logic [DATA_W-1:0] dir_view,
  input  logic [DATA_W-1:0] mode_view,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic              take_q, take_n;
  logic [DATA_W-1:0] val_q,  val_n;

  always_comb begin
    take_n = mode_rw && (sel != SEL_NONE);
    unique case (sel)
      SEL_LEVEL: val_n = level_view;
      SEL_DIR:   val_n = dir_view;
      SEL_MODE:  val_n = mode_view;
      default:   val_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      val_q  <= '0;
    end else if (rd) begin
      take_q <= take_n;
      val_q  <= val_n;
    end
  end

  assign bus_rdata = take_q ? val_q : rom_rdata;

  assert_wo_reads_rom_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel != SEL_NONE && !mode_rw) |=> (bus_rdata == rom_rdata));

  assert_miss_reads_rom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_NONE) |=> (bus_rdata == rom_rdata));
endmodule

// File: rtl/cart_gpio_overlay.sv
module cart_gpio_overlay
  import gpio_ovl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PINS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  input  logic              periph_irq,
  output logic              cart_irq_n
);
  localparam logic [ADDR_W-1:0] HW_LEVEL = ADDR_W'(BYTE_OFS_LEVEL >> 1);
  localparam logic [ADDR_W-1:0] HW_DIR   = ADDR_W'(BYTE_OFS_DIR >> 1);
  localparam logic [ADDR_W-1:0] HW_MODE  = ADDR_W'(BYTE_OFS_MODE >> 1);

  logic              rst_n_int;
  logic [PINS-1:0]   pin_sync;
  reg_sel_e          sel;
  logic [DATA_W-1:0] level_view, dir_view, mode_view;
  logic              mode_rw;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_int)
  );

  gpio_in_sync #(.PINS(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .pin_raw(pin_in), .pin_sync(pin_sync)
  );

  always_comb begin
    if      (bus_addr == HW_LEVEL) sel = SEL_LEVEL;
    else if (bus_addr == HW_DIR)   sel = SEL_DIR;
    else if (bus_addr == HW_MODE)  sel = SEL_MODE;
    else                           sel = SEL_NONE;
  end

  gpio_regfile #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .sel(sel), .wr(bus_wr), .wdata(bus_wdata),
    .pin_sync(pin_sync), .level_view(level_view), .dir_view(dir_view),
    .mode_view(mode_view), .mode_rw(mode_rw), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  gpio_rdmux #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n_int), .rd(bus_rd), .sel(sel), .mode_rw(mode_rw),
    .level_view(level_view), .dir_view(dir_view), .mode_view(mode_view),
    .rom_rdata(rom_rdata), .bus_rdata(bus_rdata)
  );

  assign rom_addr   = bus_addr;
  assign cart_irq_n = ~periph_irq;
endmodule

// File: tb/sim_cart_gpio_overlay.sv
`timescale 1ns/1ps
module sim_cart_gpio_overlay;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, bus_rd, bus_wr, periph_irq, cart_irq_n;
  logic [11:0] bus_addr, rom_addr;
  logic [15:0] bus_wdata, bus_rdata, rom_rdata;
  logic [3:0]  pin_in, pin_out, pin_oe;

  cart_gpio_overlay u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .periph_irq(periph_irq),
    .cart_irq_n(cart_irq_n)
  );

  function automatic logic [15:0] rom_word(input logic [11:0] a);
    return {a[7:0], ~a[7:0]} ^ 16'h3C5A;
  endfunction

  always @(posedge clk) rom_rdata <= rom_word(rom_addr);

  int    n_checks = 0, n_fail = 0;
  string cur_tag = "R1";
  bit    running = 0, done = 0;

  // behavioural reference state
  logic [15:0] m_level, m_dir, m_mode, m_exp;
  logic [3:0]  m_s1, m_s2;
  bit          m_pend;

  function automatic logic [15:0] model_read(input logic [11:0] a);
    logic [15:0] v;
    if (m_mode[0] && (a == 12'h062 || a == 12'h063 || a == 12'h064)) begin
      if (a == 12'h062) begin
        v = 16'h0;
        for (int i = 0; i < 4; i++) v[i] = m_dir[i] ? m_level[i] : m_s2[i];
      end else if (a == 12'h063) v = m_dir;
      else v = m_mode;
    end else v = rom_word(a);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_level = 0; m_dir = 0; m_mode = 0; m_s1 = 0; m_s2 = 0; m_pend = 0; m_exp = 0;
    end else begin
      m_pend = bus_rd;
      if (bus_rd) m_exp = model_read(bus_addr);
      if (bus_wr) begin
        if (bus_addr == 12'h062) m_level = {12'h0, bus_wdata[3:0]};
        else if (bus_addr == 12'h063) m_dir = {12'h0, bus_wdata[3:0]};
        else if (bus_addr == 12'h064) m_mode = {15'h0, bus_wdata[0]};
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (running) begin
      chk("R6 oe", {12'h0, pin_oe}, m_dir);
      chk("R6 out", {12'h0, pin_out}, m_level & m_dir);
      chk("R8 irq", {15'h0, cart_irq_n}, {15'h0, ~periph_irq});
      if (m_pend) chk(cur_tag, bus_rdata, m_exp);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    cur_tag = tag; bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    pin_in = 0; periph_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    running = 1;
    chk("R1 reset oe", {12'h0, pin_oe}, 16'h0);
    rd("R1", 12'h062);
    // write-only mode: port locations read ROM
    wr(12'h062, 16'h0005);
    wr(12'h063, 16'h0007);
    rd("R3", 12'h062); rd("R3", 12'h063); rd("R3", 12'h064);
    // switch to read/write, unused bits masked
    wr(12'h064, 16'hFFFF);
    rd("R4", 12'h064);
    wr(12'h063, 16'hFFFF);
    rd("R2", 12'h063);
    wr(12'h062, 16'hFFF3);
    rd("R2", 12'h062);
    // serial-style directions and input merging
    wr(12'h063, 16'h0005);
    wr(12'h062, 16'h000F);
    pin_in = 4'b1010;
    rd("R7", 12'h062);
    repeat (3) @(negedge clk);
    rd("R7", 12'h062);
    pin_in = 4'b0000;
    rd("R7", 12'h062);
    repeat (3) @(negedge clk);
    rd("R7", 12'h062);
    wr(12'h063, 16'h0007);
    rd("R4", 12'h063);
    // other addresses: writes ignored, reads from ROM
    wr(12'h061, 16'h0000); wr(12'h065, 16'h0000); wr(12'h000, 16'h000A);
    rd("R5", 12'h061); rd("R5", 12'h065); rd("R5", 12'hFFF);
    rd("R5", 12'h063); rd("R5", 12'h062);
    // interrupt inversion
    periph_irq = 1; @(negedge clk); @(negedge clk);
    periph_irq = 0; @(negedge clk);
    // global mode bit: high bits alone give write-only
    wr(12'h064, 16'h0002);
    rd("R9", 12'h062); rd("R9", 12'h063); rd("R9", 12'h064);
    wr(12'h064, 16'h0001);
    rd("R9", 12'h062);
    repeat (2) @(negedge clk);
    running = 0; done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule